// File: doc/BRIEF.md
# Two-Thread Miss-Driven Pipeline Switch Controller

This block steers a single in-order five-stage pipeline that two hardware threads share. One thread keeps the pipeline until one of its instructions reports a long-latency event, typically a data-cache miss, while it is in the memory stage. In that same cycle the controller kills the missing instruction and every younger instruction of the same thread that sits in the fetch, decode and execute stages. It also records the missing instruction's PC as that thread's restart point. One cycle later it hands fetch to the other thread and issues a one-cycle redirect that carries that thread's saved restart PC.

If no other thread can run, fetch idles and the pipeline fills with bubbles. A resolve notification for a waiting thread wakes the pipeline and replays that thread from its saved PC. When the running thread is still busy, a resolved thread is only marked ready. It takes over at the running thread's next miss. The write-back stage is not observed: instructions that reach it always retire. The data path, the caches and forwarding are outside the block.

Top module: `cgmt_switch_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, thread 0 is active (`active_tid_o`=0), `fetch_idle_o`=0, `redirect_vld_o`=0 and `flush_o`=0. Thread t's restart PC starts at PC_RST_BASE + t*PC_RST_STRIDE.
- R2: A miss is accepted only if `miss_i`=1, the memory-stage valid bit (`stage_vld_i[3]`) is 1, the memory-stage tag equals `active_tid_o`, and `fetch_idle_o`=0. Any other miss is ignored: no flush, no switch, and no change to any restart PC.
- R3: In the cycle a miss is accepted, `flush_o[k]` is 1 for each observed stage k that is valid and tagged with the missing thread. The bit order is k=0 fetch, 1 decode, 2 execute, 3 memory. Stages holding the other thread are left alone.
- R4: On the clock edge that ends an accepted miss, the next ready thread in round-robin order from the missing one becomes active. `redirect_vld_o` is 1 in the following cycle and `redirect_pc_o` carries that thread's restart PC.
- R5: An accepted miss stores `miss_pc_i` as the missing thread's restart PC. A later redirect to that thread carries exactly this PC.
- R6: A thread that has never missed is redirected to its reset PC from R1.
- R7: If no other thread is ready, `fetch_idle_o` becomes 1 after the accepted miss, with no redirect. It stays 1, and `active_tid_o` stays unchanged, until a resolve arrives.
- R8: While idle, a resolve (`resolve_vld_i`=1) for a waiting thread makes that thread active on the next edge. `fetch_idle_o` drops and a redirect to its saved restart PC is issued.
- R9: A resolve that arrives while another thread runs causes no switch and no redirect. The resolved thread becomes eligible at the next accepted miss.
- R10: A resolve in the same cycle as an accepted miss of the other thread counts as ready, so the controller switches instead of idling.
- R11: `redirect_vld_o` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stage_vld_i | input | 4 | Valid bit per observed stage (0 fetch .. 3 memory) |
| stage_tid_i | input | 4 | Thread tag per observed stage, TID_W bits each |
| miss_i | input | 1 | Long-latency miss reported by the memory-stage instruction |
| miss_pc_i | input | 32 | PC of the missing instruction |
| resolve_vld_i | input | 1 | A thread's outstanding miss has been serviced |
| resolve_tid_i | input | 1 | Thread whose miss was serviced |
| flush_o | output | 4 | Per-stage squash, same cycle as the accepted miss |
| active_tid_o | output | 1 | Thread that currently owns fetch |
| fetch_idle_o | output | 1 | No thread can run; fetch issues bubbles |
| redirect_vld_o | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc_o | output | 32 | Restart PC of the active thread |

## Verification
The main function is exercised with misses whose shadow holds a mix of thread tags. This shows that the flush vector follows both the valid bits and the tags, and is not a fixed stage mask. Decoy misses are also applied, tagged with the inactive thread or carried by an invalid memory stage, to separate correct acceptance from a raw `miss_i` decode. Restart PCs are checked on three paths: a thread that has never run, a thread woken from idle, and a thread resumed through a later miss of the other thread. This separates saved PCs from reset PCs. A resolve that lands in the same cycle as a miss distinguishes a registered ready flag from a forwarded one.

// File: rtl/cgmt_pkg.sv
package cgmt_pkg;
  typedef enum logic {
    SCH_RUN  = 1'b0,
    SCH_IDLE = 1'b1
  } sched_state_e;
endpackage

// File: rtl/cgmt_miss_detect.sv
module cgmt_miss_detect #(
  parameter int NOBS     = 4,
  parameter int TID_W    = 1,
  parameter int MISS_STG = NOBS - 1
) (
  input  logic [NOBS-1:0]       stage_vld_i,
  input  logic [NOBS*TID_W-1:0] stage_tid_i,
  input  logic                  miss_i,
  input  logic [TID_W-1:0]      active_tid_i,
  input  logic                  idle_i,
  output logic                  miss_acc_o,
  output logic [NOBS-1:0]       flush_o
);
  logic [TID_W-1:0] mem_tid;
  assign mem_tid    = stage_tid_i[MISS_STG*TID_W +: TID_W];
  assign miss_acc_o = miss_i & stage_vld_i[MISS_STG] & (mem_tid == active_tid_i) & ~idle_i;

  // squash the missing instruction and its same-thread shadow
  for (genvar g = 0; g < NOBS; g++) begin : g_flush
    assign flush_o[g] = miss_acc_o & stage_vld_i[g] &
                        (stage_tid_i[g*TID_W +: TID_W] == active_tid_i);
  end
endmodule

// File: rtl/cgmt_thread_ctx.sv
module cgmt_thread_ctx #(
  parameter int              NTHR          = 2,
  parameter int              TID_W         = 1,
  parameter int              PC_W          = 32,
  parameter logic [PC_W-1:0] PC_RST_BASE   = '0,
  parameter logic [PC_W-1:0] PC_RST_STRIDE = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 miss_acc_i,
  input  logic [TID_W-1:0]     miss_tid_i,
  input  logic [PC_W-1:0]      miss_pc_i,
  input  logic                 resolve_vld_i,
  input  logic [TID_W-1:0]     resolve_tid_i,
  output logic [NTHR-1:0]      blocked_o,
  output logic [NTHR-1:0]      ready_nxt_o,
  output logic [NTHR*PC_W-1:0] resume_pc_o
);
  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam logic [PC_W-1:0] RST_PC = PC_RST_BASE + PC_W'(g) * PC_RST_STRIDE;
    logic            blocked_q;
    logic [PC_W-1:0] pc_q;
    logic            hit_miss, hit_res;

    assign hit_miss = miss_acc_i & (miss_tid_i == TID_W'(g));
    assign hit_res  = resolve_vld_i & (resolve_tid_i == TID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        blocked_q <= 1'b0;
        pc_q      <= RST_PC;
      end else if (hit_miss) begin
        blocked_q <= 1'b1;
        pc_q      <= miss_pc_i;
      end else if (hit_res) begin
        blocked_q <= 1'b0;
      end
    end

    assign blocked_o[g]                  = blocked_q;
    assign ready_nxt_o[g]                = ~blocked_q | hit_res;
    assign resume_pc_o[g*PC_W +: PC_W]   = pc_q;
  end
endmodule

// File: rtl/cgmt_sched.sv
module cgmt_sched
  import cgmt_pkg::*;
#(
  parameter int NTHR  = 2,
  parameter int TID_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             miss_acc_i,
  input  logic [NTHR-1:0]  ready_nxt_i,
  input  logic [NTHR-1:0]  blocked_i,
  input  logic             resolve_vld_i,
  input  logic [TID_W-1:0] resolve_tid_i,
  output logic [TID_W-1:0] active_tid_o,
  output logic             idle_o,
  output logic             redirect_o
);
  sched_state_e     state_q;
  logic [TID_W-1:0] active_q, nxt_tid;
  logic             nxt_found, res_acc, redirect_q;

  // round robin from the thread after the active one
  always_comb begin
    nxt_found = 1'b0;
    nxt_tid   = active_q;
    for (int i = 1; i < NTHR; i++) begin
      logic [TID_W-1:0] cand;
      cand = TID_W'((int'(active_q) + i) % NTHR);
      if (!nxt_found && ready_nxt_i[cand]) begin
        nxt_found = 1'b1;
        nxt_tid   = cand;
      end
    end
  end

  assign res_acc = resolve_vld_i & (int'(resolve_tid_i) < NTHR) & blocked_i[resolve_tid_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SCH_RUN;
      active_q   <= '0;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= 1'b0;
      unique case (state_q)
        SCH_RUN: if (miss_acc_i) begin
          if (nxt_found) begin
            active_q   <= nxt_tid;
            redirect_q <= 1'b1;
          end else begin
            state_q <= SCH_IDLE;
          end
        end
        SCH_IDLE: if (res_acc) begin
          active_q   <= resolve_tid_i;
          redirect_q <= 1'b1;
          state_q    <= SCH_RUN;
        end
        default: state_q <= SCH_RUN;
      endcase
    end
  end

  assign active_tid_o = active_q;
  assign idle_o       = (state_q == SCH_IDLE);
  assign redirect_o   = redirect_q;
endmodule

// File: rtl/cgmt_switch_ctrl.sv
module cgmt_switch_ctrl #(
  parameter int              NSTG          = 5,
  parameter int              NTHR          = 2,
  parameter int              PC_W          = 32,
  parameter logic [PC_W-1:0] PC_RST_BASE   = 32'h0000_1000,
  parameter logic [PC_W-1:0] PC_RST_STRIDE = 32'h0000_1000,
  localparam int             NOBS          = NSTG - 1,
  localparam int             TID_W         = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NOBS-1:0]       stage_vld_i,
  input  logic [NOBS*TID_W-1:0] stage_tid_i,
  input  logic                  miss_i,
  input  logic [PC_W-1:0]       miss_pc_i,
  input  logic                  resolve_vld_i,
  input  logic [TID_W-1:0]      resolve_tid_i,
  output logic [NOBS-1:0]       flush_o,
  output logic [TID_W-1:0]      active_tid_o,
  output logic                  fetch_idle_o,
  output logic                  redirect_vld_o,
  output logic [PC_W-1:0]       redirect_pc_o
);
  logic                  miss_acc;
  logic [NTHR-1:0]       blocked, ready_nxt;
  logic [NTHR*PC_W-1:0]  resume_pc;

  cgmt_miss_detect #(.NOBS(NOBS), .TID_W(TID_W), .MISS_STG(NOBS - 1)) u_detect (
    .stage_vld_i (stage_vld_i),
    .stage_tid_i (stage_tid_i),
    .miss_i      (miss_i),
    .active_tid_i(active_tid_o),
    .idle_i      (fetch_idle_o),
    .miss_acc_o  (miss_acc),
    .flush_o     (flush_o)
  );

  cgmt_thread_ctx #(
    .NTHR(NTHR), .TID_W(TID_W), .PC_W(PC_W),
    .PC_RST_BASE(PC_RST_BASE), .PC_RST_STRIDE(PC_RST_STRIDE)
  ) u_ctx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_acc_i   (miss_acc),
    .miss_tid_i   (active_tid_o),
    .miss_pc_i    (miss_pc_i),
    .resolve_vld_i(resolve_vld_i),
    .resolve_tid_i(resolve_tid_i),
    .blocked_o    (blocked),
    .ready_nxt_o  (ready_nxt),
    .resume_pc_o  (resume_pc)
  );

  cgmt_sched #(.NTHR(NTHR), .TID_W(TID_W)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .miss_acc_i   (miss_acc),
    .ready_nxt_i  (ready_nxt),
    .blocked_i    (blocked),
    .resolve_vld_i(resolve_vld_i),
    .resolve_tid_i(resolve_tid_i),
    .active_tid_o (active_tid_o),
    .idle_o       (fetch_idle_o),
    .redirect_o   (redirect_vld_o)
  );

  assign redirect_pc_o = resume_pc[active_tid_o*PC_W +: PC_W];
endmodule

// File: rtl/cgmt_switch_ctrl_chk.sv
module cgmt_switch_ctrl_chk #(
  parameter int NOBS  = 4,
  parameter int TID_W = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NOBS-1:0]       stage_vld_i,
  input logic [NOBS*TID_W-1:0] stage_tid_i,
  input logic                  miss_i,
  input logic                  resolve_vld_i,
  input logic [NOBS-1:0]       flush_o,
  input logic [TID_W-1:0]      active_tid_o,
  input logic                  fetch_idle_o,
  input logic                  redirect_vld_o
);
  logic acc;
  assign acc = miss_i & stage_vld_i[NOBS-1] & ~fetch_idle_o &
               (stage_tid_i[(NOBS-1)*TID_W +: TID_W] == active_tid_o);

  // R11
  redirect_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_vld_o |=> !redirect_vld_o);

  // R3
  flush_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o & ~stage_vld_i) == '0);

  // R2
  no_miss_no_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |-> flush_o == '0);

  // R4
  miss_reacts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (redirect_vld_o || fetch_idle_o));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_idle_o && !resolve_vld_i) |=> (fetch_idle_o && $stable(active_tid_o)));

  // R8
  redirect_not_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_vld_o |-> !fetch_idle_o);
endmodule

bind cgmt_switch_ctrl cgmt_switch_ctrl_chk #(.NOBS(NOBS), .TID_W(TID_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .stage_vld_i   (stage_vld_i),
  .stage_tid_i   (stage_tid_i),
  .miss_i        (miss_i),
  .resolve_vld_i (resolve_vld_i),
  .flush_o       (flush_o),
  .active_tid_o  (active_tid_o),
  .fetch_idle_o  (fetch_idle_o),
  .redirect_vld_o(redirect_vld_o)
);

// File: tb/cgmt_switch_ctrl_tb.sv
module cgmt_switch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  stage_vld_i = '0;
  logic [3:0]  stage_tid_i = '0;
  logic        miss_i = 1'b0;
  logic [31:0] miss_pc_i = '0;
  logic        resolve_vld_i = 1'b0;
  logic        resolve_tid_i = 1'b0;
  logic [3:0]  flush_o;
  logic        active_tid_o;
  logic        fetch_idle_o;
  logic        redirect_vld_o;
  logic [31:0] redirect_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cgmt_switch_ctrl dut_i (
    .clk_i, .rst_ni, .stage_vld_i, .stage_tid_i, .miss_i, .miss_pc_i,
    .resolve_vld_i, .resolve_tid_i, .flush_o, .active_tid_o,
    .fetch_idle_o, .redirect_vld_o, .redirect_pc_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] vld, logic [3:0] tid, logic m, logic [31:0] pc,
                       logic rv, logic rt);
    stage_vld_i = vld; stage_tid_i = tid; miss_i = m; miss_pc_i = pc;
    resolve_vld_i = rv; resolve_tid_i = rt;
  endtask

  task automatic quiet();
    drive(4'b0, 4'b0, 1'b0, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 active", active_tid_o, 0);
    chk("R1 idle", fetch_idle_o, 0);
    chk("R1 redirect", redirect_vld_o, 0);
    chk("R1 flush", flush_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 active after release", active_tid_o, 0);
  endtask

  task automatic t_switch();
    @(negedge clk_i);
    drive(4'b1111, 4'b0010, 1'b1, 32'h1234, 1'b0, 1'b0);
    #1 chk("R3 mixed-tag flush", flush_o, 4'b1101);
    @(negedge clk_i);
    chk("R4 active", active_tid_o, 1);
    chk("R4 redirect", redirect_vld_o, 1);
    chk("R6 reset pc of thread1", redirect_pc_o, 32'h2000);
    quiet();
    @(negedge clk_i);
    chk("R11 single pulse", redirect_vld_o, 0);
  endtask

  task automatic t_ignore();
    @(negedge clk_i);
    drive(4'b1111, 4'b0000, 1'b1, 32'hdead, 1'b0, 1'b0);
    #1 chk("R2 wrong tag flush", flush_o, 0);
    @(negedge clk_i);
    chk("R2 wrong tag no redirect", redirect_vld_o, 0);
    chk("R2 wrong tag active", active_tid_o, 1);
    drive(4'b0111, 4'b1111, 1'b1, 32'hbeef, 1'b0, 1'b0);
    #1 chk("R2 invalid mem flush", flush_o, 0);
    @(negedge clk_i);
    chk("R2 invalid mem active", active_tid_o, 1);
    chk("R2 invalid mem idle", fetch_idle_o, 0);
    quiet();
  endtask

  task automatic t_all_blocked();
    @(negedge clk_i);
    drive(4'b1111, 4'b1111, 1'b1, 32'h2222, 1'b0, 1'b0);
    #1 chk("R3 full flush", flush_o, 4'b1111);
    @(negedge clk_i);
    chk("R7 idle", fetch_idle_o, 1);
    chk("R7 no redirect", redirect_vld_o, 0);
    chk("R7 active held", active_tid_o, 1);
    #1 chk("R2 miss while idle flush", flush_o, 0);
    @(negedge clk_i);
    chk("R7 still idle", fetch_idle_o, 1);
    quiet();
  endtask

  task automatic t_wake();
    @(negedge clk_i);
    drive(4'b0, 4'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    @(negedge clk_i);
    chk("R8 idle drops", fetch_idle_o, 0);
    chk("R8 active", active_tid_o, 0);
    chk("R8 redirect", redirect_vld_o, 1);
    chk("R5 saved pc thread0", redirect_pc_o, 32'h1234);
    quiet();
  endtask

  task automatic t_ready_wait();
    @(negedge clk_i);
    drive(4'b0, 4'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    @(negedge clk_i);
    chk("R9 no switch", active_tid_o, 0);
    chk("R9 no redirect", redirect_vld_o, 0);
    drive(4'b1111, 4'b0000, 1'b1, 32'h1300, 1'b0, 1'b0);
    @(negedge clk_i);
    chk("R9 switch at next miss", active_tid_o, 1);
    chk("R5 saved pc thread1", redirect_pc_o, 32'h2222);
    quiet();
  endtask

  task automatic t_same_cycle();
    @(negedge clk_i);
    drive(4'b1000, 4'b1000, 1'b1, 32'h2400, 1'b1, 1'b0);
    #1 chk("R3 only mem flushed", flush_o, 4'b1000);
    @(negedge clk_i);
    chk("R10 no idle", fetch_idle_o, 0);
    chk("R10 active", active_tid_o, 0);
    chk("R10 redirect", redirect_vld_o, 1);
    chk("R10 pc", redirect_pc_o, 32'h1300);
    quiet();
  endtask

  initial begin
    t_reset();
    t_switch();
    t_ignore();
    t_all_blocked();
    t_wake();
    t_ready_wait();
    t_same_cycle();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule